// File: doc/BRIEF.md
# Virtual-Supervisor Interrupt Enable/Pending Alias Unit

This block owns the machine-level interrupt-enable word and the software-writable part of the interrupt-pending word of a hart that implements the hypervisor extension. It answers CSR accesses to the supervisor interrupt views (sie at 0x104, sip at 0x144) and to the virtual-supervisor views (vsie at 0x204, vsip at 0x244). It works out which underlying bits each access may see and change, and it updates those bits in place. The full enable and pending words are driven out to the interrupt arbiter.

Interrupt bits for the virtual-supervisor level sit one position above their supervisor counterparts in the machine words. A guest sees them through the aliased views as if they were ordinary supervisor bits. Reads therefore shift those bits down by one, and writes shift the data and mask up by one. The hypervisor delegation word gates these accesses. The machine delegation word gates the plain supervisor views. When the hart runs virtualized, accesses to sie and sip are steered to the vsie and vsip behaviour. The timer and external pending bits of the virtual level are not stored here: they come from input pins and are read-only through this path.

Top module: `hvirq_csr_alias`

## Requirements
- R1: While reset is asserted and just after it, `mie_q`, `mip_q` (with both interrupt input pins low), `rvalid` and `rdata` are all zero.
- R2: `rvalid` is high exactly in the cycle after a cycle with `req_valid` high. `rdata` then holds the value of the addressed view from before that access's update.
- R3: A vsie read returns `(mie & hideleg & 0x444) >> 1`, so enable bits 2, 6 and 10 show at bits 1, 5 and 9.
- R4: A vsie update changes only mie bits in `(mask << 1) & hideleg & 0x444`, loading them from `data << 1`. Every other mie bit holds its value.
- R5: A vsip access updates only mip bits in `(mask << 1) & hideleg & 0x004`, loading them from `data << 1`. It returns `(mip & 0x444) >> 1` with no delegation gating on the read.
- R6: Pending bit 6 follows input `vs_timer_irq` and bit 10 follows `vs_ext_irq`. Both show in `mip_q` and in vsip reads, and no CSR write changes them.
- R7: With `virt_mode` high, an access to address 0x104 behaves exactly as a vsie access and one to 0x144 exactly as a vsip access.
- R8: With `virt_mode` low, a read of 0x104 returns `mie & mideleg`.
- R9: With `virt_mode` low, an update of 0x104 changes only mie bits in `mask & 0x222` (bits 1, 5, 9), whatever mideleg holds. All other mie bits hold.
- R10: With `virt_mode` low, a 0x144 access updates only mip bits in `mask & mideleg & 0x002` and returns `mip & mideleg`.
- R11: Operation codes are 0 read (empty mask), 1 write (mask all ones, data = wdata), 2 set (mask = wdata, data all ones) and 3 clear (mask = wdata, data all zeros).
- R12: An access to any other address returns zero and changes neither mie nor mip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | CSR access request in this cycle |
| req_addr | input | ADDR_W (12) | CSR address |
| req_op | input | 2 | Operation: 0 read, 1 write, 2 set, 3 clear |
| req_wdata | input | XLEN (64) | Write data, or bit mask for set and clear |
| virt_mode | input | 1 | Hart is running virtualized |
| mideleg | input | XLEN (64) | Machine interrupt delegation word |
| hideleg | input | XLEN (64) | Hypervisor interrupt delegation word |
| vs_timer_irq | input | 1 | Virtual-supervisor timer pending source |
| vs_ext_irq | input | 1 | Virtual-supervisor external pending source |
| rdata | output | XLEN (64) | Registered read data |
| rvalid | output | 1 | Read data valid, one cycle after the request |
| mie_q | output | XLEN (64) | Current machine interrupt-enable word |
| mip_q | output | XLEN (64) | Current machine interrupt-pending word |

## Verification
The bench runs the same 0x104 access under both `virt_mode` values. A unit that failed to redirect would write S bits instead of VS bits, or skip the shift and return enables at the wrong positions. Delegation is varied separately for each view. A design that gated guest accesses with mideleg, or gated supervisor writes to sie with it, would let through or block bits the bench expects the opposite for. Writes of all ones to vsip, with the timer and external inputs high, target read-only bits. A wrong writable mask would latch bit 6 or 10 so that it stays set after the pins drop. Zero writes and clears check that bits outside the effective mask survive an update. This catches a design that writes back the whole word.

// File: rtl/hvirq_pkg.sv
package hvirq_pkg;

   // interrupt bit positions inside the machine enable/pending words
   localparam int unsigned SSI_BIT  = 1;
   localparam int unsigned VSSI_BIT = 2;
   localparam int unsigned STI_BIT  = 5;
   localparam int unsigned VSTI_BIT = 6;
   localparam int unsigned SEI_BIT  = 9;
   localparam int unsigned VSEI_BIT = 10;

   // bit groups, kept 16 bits wide and widened where used
   localparam logic [15:0] S_GROUP   = 16'h0222;
   localparam logic [15:0] VS_GROUP  = 16'h0444;
   localparam logic [15:0] SIP_WR    = 16'h0002;
   localparam logic [15:0] VSIP_WR   = 16'h0004;
   localparam logic [15:0] MIE_IMPL  = 16'h0666;
   localparam logic [15:0] MIP_STORE = 16'h0006;

   // CSR numbers whose decoding this block depends on
   localparam logic [11:0] A_SIE  = 12'h104;
   localparam logic [11:0] A_SIP  = 12'h144;
   localparam logic [11:0] A_VSIE = 12'h204;
   localparam logic [11:0] A_VSIP = 12'h244;

   typedef enum logic [1:0] {
      OP_READ  = 2'd0,
      OP_WRITE = 2'd1,
      OP_SET   = 2'd2,
      OP_CLEAR = 2'd3
   } csr_op_e;

   typedef enum logic [2:0] {
      TGT_NONE = 3'd0,
      TGT_SIE  = 3'd1,
      TGT_SIP  = 3'd2,
      TGT_VSIE = 3'd3,
      TGT_VSIP = 3'd4
   } alias_tgt_e;

endpackage

// File: rtl/hvirq_op_expand.sv
module hvirq_op_expand #(
   parameter int unsigned XLEN = 64
) (
   input  logic                 valid,
   input  hvirq_pkg::csr_op_e   op,
   input  logic [XLEN-1:0]      wdata,
   output logic [XLEN-1:0]      mask,
   output logic [XLEN-1:0]      data
);
   import hvirq_pkg::*;

   always_comb begin
      mask = '0;
      data = '0;
      if (valid) begin
         unique case (op)
            OP_READ:  begin mask = '0;    data = '0;    end
            OP_WRITE: begin mask = '1;    data = wdata; end
            OP_SET:   begin mask = wdata; data = '1;    end
            OP_CLEAR: begin mask = wdata; data = '0;    end
            default:  begin mask = '0;    data = '0;    end
         endcase
      end
   end

endmodule

// File: rtl/hvirq_alias_route.sv
module hvirq_alias_route #(
   parameter int unsigned XLEN   = 64,
   parameter int unsigned ADDR_W = 12
) (
   input  logic [ADDR_W-1:0]        addr,
   input  logic                     virt,
   input  logic [XLEN-1:0]          mask,
   input  logic [XLEN-1:0]          data,
   input  logic [XLEN-1:0]          mideleg,
   input  logic [XLEN-1:0]          hideleg,
   input  logic [XLEN-1:0]          mie_cur,
   input  logic [XLEN-1:0]          mip_cur,
   output hvirq_pkg::alias_tgt_e    tgt,
   output logic [XLEN-1:0]          mie_wmask,
   output logic [XLEN-1:0]          mie_wdata,
   output logic [XLEN-1:0]          mip_wmask,
   output logic [XLEN-1:0]          mip_wdata,
   output logic [XLEN-1:0]          rd_value
);
   import hvirq_pkg::*;

   localparam logic [XLEN-1:0] S_SET   = XLEN'(S_GROUP);
   localparam logic [XLEN-1:0] VS_SET  = XLEN'(VS_GROUP);
   localparam logic [XLEN-1:0] SIP_W   = XLEN'(SIP_WR);
   localparam logic [XLEN-1:0] VSIP_W  = XLEN'(VSIP_WR);

   always_comb begin
      tgt = TGT_NONE;
      if (addr == ADDR_W'(A_SIE))       tgt = virt ? TGT_VSIE : TGT_SIE;
      else if (addr == ADDR_W'(A_SIP))  tgt = virt ? TGT_VSIP : TGT_SIP;
      else if (addr == ADDR_W'(A_VSIE)) tgt = TGT_VSIE;
      else if (addr == ADDR_W'(A_VSIP)) tgt = TGT_VSIP;
   end

   always_comb begin
      mie_wmask = '0;
      mie_wdata = '0;
      mip_wmask = '0;
      mip_wdata = '0;
      rd_value  = '0;
      unique case (tgt)
         TGT_SIE: begin
            rd_value  = mie_cur & mideleg;
            mie_wmask = mask & S_SET;
            mie_wdata = data;
         end
         TGT_SIP: begin
            rd_value  = mip_cur & mideleg;
            mip_wmask = mask & mideleg & SIP_W;
            mip_wdata = data;
         end
         TGT_VSIE: begin
            rd_value  = (mie_cur & hideleg & VS_SET) >> 1;
            mie_wmask = (mask << 1) & hideleg & VS_SET;
            mie_wdata = data << 1;
         end
         TGT_VSIP: begin
            rd_value  = (mip_cur & VS_SET) >> 1;
            mip_wmask = (mask << 1) & hideleg & VSIP_W;
            mip_wdata = data << 1;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/hvirq_bit_store.sv
module hvirq_bit_store #(
   parameter int unsigned     XLEN = 64,
   parameter logic [XLEN-1:0] IMPL = '0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [XLEN-1:0] wmask,
   input  logic [XLEN-1:0] wdata,
   output logic [XLEN-1:0] q
);

   for (genvar b = 0; b < XLEN; b++) begin : g_bit
      if (IMPL[b]) begin : g_flop
         logic bit_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        bit_q <= 1'b0;
            else if (wmask[b]) bit_q <= wdata[b];
         end
         assign q[b] = bit_q;
      end else begin : g_tie
         assign q[b] = 1'b0;
      end
   end

   // R4 R9 R12: bits outside the applied mask never move
   held_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((q ^ $past(q)) & ~$past(wmask)) == '0);

endmodule

// File: rtl/hvirq_csr_alias.sv
module hvirq_csr_alias #(
   parameter int unsigned XLEN   = 64,
   parameter int unsigned ADDR_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [1:0]        req_op,
   input  logic [XLEN-1:0]   req_wdata,
   input  logic              virt_mode,
   input  logic [XLEN-1:0]   mideleg,
   input  logic [XLEN-1:0]   hideleg,
   input  logic              vs_timer_irq,
   input  logic              vs_ext_irq,
   output logic [XLEN-1:0]   rdata,
   output logic              rvalid,
   output logic [XLEN-1:0]   mie_q,
   output logic [XLEN-1:0]   mip_q
);
   import hvirq_pkg::*;

   if (XLEN < 16) begin : g_bad_xlen
      $error("hvirq_csr_alias: XLEN must cover bit 10 and the group masks");
   end
   if (ADDR_W < 10) begin : g_bad_aw
      $error("hvirq_csr_alias: ADDR_W too narrow for the CSR numbers");
   end

   localparam logic [XLEN-1:0] S_SET  = XLEN'(S_GROUP);
   localparam logic [XLEN-1:0] VS_SET = XLEN'(VS_GROUP);

   logic [XLEN-1:0] op_mask, op_data;
   logic [XLEN-1:0] mie_wmask, mie_wdata, mip_wmask, mip_wdata, rd_value;
   logic [XLEN-1:0] mip_sw, mip_hw;
   alias_tgt_e      tgt;
   logic            rd_vs_q;

   hvirq_op_expand #(.XLEN(XLEN)) u_op (
      .valid (req_valid),
      .op    (csr_op_e'(req_op)),
      .wdata (req_wdata),
      .mask  (op_mask),
      .data  (op_data)
   );

   assign mip_hw = (XLEN'(vs_timer_irq) << VSTI_BIT) | (XLEN'(vs_ext_irq) << VSEI_BIT);
   assign mip_q  = mip_sw | mip_hw;

   hvirq_alias_route #(.XLEN(XLEN), .ADDR_W(ADDR_W)) u_route (
      .addr      (req_addr),
      .virt      (virt_mode),
      .mask      (op_mask),
      .data      (op_data),
      .mideleg   (mideleg),
      .hideleg   (hideleg),
      .mie_cur   (mie_q),
      .mip_cur   (mip_q),
      .tgt       (tgt),
      .mie_wmask (mie_wmask),
      .mie_wdata (mie_wdata),
      .mip_wmask (mip_wmask),
      .mip_wdata (mip_wdata),
      .rd_value  (rd_value)
   );

   hvirq_bit_store #(.XLEN(XLEN), .IMPL(XLEN'(MIE_IMPL))) u_mie (
      .clk   (clk),
      .rst_n (rst_n),
      .wmask (mie_wmask),
      .wdata (mie_wdata),
      .q     (mie_q)
   );

   hvirq_bit_store #(.XLEN(XLEN), .IMPL(XLEN'(MIP_STORE))) u_mip (
      .clk   (clk),
      .rst_n (rst_n),
      .wmask (mip_wmask),
      .wdata (mip_wdata),
      .q     (mip_sw)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata   <= '0;
         rvalid  <= 1'b0;
         rd_vs_q <= 1'b0;
      end else begin
         rdata   <= req_valid ? rd_value : '0;
         rvalid  <= req_valid;
         rd_vs_q <= req_valid && (tgt == TGT_VSIE || tgt == TGT_VSIP);
      end
   end

   // R2
   rvalid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rvalid);
   // R2
   rvalid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rvalid);
   // R3
   vs_read_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rvalid && rd_vs_q) |-> ((rdata & ~S_SET) == '0));
   // R4
   vsie_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && tgt == TGT_VSIE) |=>
      (((mie_q ^ $past(mie_q)) & ~($past(hideleg) & VS_SET)) == '0));
   // R5
   vsip_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && tgt == TGT_VSIP && !hideleg[VSSI_BIT]) |=> $stable(mip_sw));
   // R12
   unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && tgt == TGT_NONE) |=> (rdata == '0 && $stable(mie_q) && $stable(mip_sw)));

endmodule

// File: tb/hvirq_csr_alias_bench.sv
module hvirq_csr_alias_bench;
   localparam int XLEN = 64;

   typedef struct packed {
      logic [11:0] addr;
      logic [1:0]  op;
      logic [15:0] wd;
      logic        virt;
      logic [15:0] mid;
      logic [15:0] hid;
      logic        vt;
      logic        ve;
      logic [7:0]  req;
   } vec_t;

   localparam int NV = 16;
   localparam vec_t VECS [NV] = '{
      '{12'h104, 2'd1, 16'hFFFF, 1'b0, 16'h0222, 16'h0444, 1'b0, 1'b0, 8'd9 },  // R9
      '{12'h104, 2'd0, 16'h0000, 1'b0, 16'h0022, 16'h0444, 1'b0, 1'b0, 8'd8 },  // R8
      '{12'h204, 2'd1, 16'hFFFF, 1'b0, 16'h0000, 16'h0044, 1'b0, 1'b0, 8'd4 },  // R4
      '{12'h204, 2'd0, 16'h0000, 1'b0, 16'h0000, 16'h0444, 1'b0, 1'b0, 8'd3 },  // R3
      '{12'h104, 2'd0, 16'h0000, 1'b1, 16'hFFFF, 16'h0004, 1'b0, 1'b0, 8'd7 },  // R7
      '{12'h104, 2'd3, 16'h0002, 1'b1, 16'h0000, 16'h0444, 1'b0, 1'b0, 8'd7 },  // R7 R11
      '{12'h204, 2'd2, 16'h0200, 1'b0, 16'h0000, 16'h0444, 1'b0, 1'b0, 8'd11},  // R11
      '{12'h144, 2'd2, 16'hFFFF, 1'b0, 16'h0002, 16'h0000, 1'b0, 1'b0, 8'd10},  // R10
      '{12'h144, 2'd2, 16'h0002, 1'b0, 16'h0000, 16'h0000, 1'b0, 1'b0, 8'd10},  // R10
      '{12'h244, 2'd1, 16'hFFFF, 1'b0, 16'h0000, 16'h0444, 1'b1, 1'b1, 8'd5 },  // R5 R6
      '{12'h244, 2'd0, 16'h0000, 1'b0, 16'h0000, 16'h0000, 1'b0, 1'b1, 8'd6 },  // R6
      '{12'h144, 2'd3, 16'h0002, 1'b1, 16'hFFFF, 16'h0000, 1'b0, 1'b0, 8'd7 },  // R7
      '{12'h244, 2'd3, 16'h0002, 1'b0, 16'h0000, 16'h0004, 1'b0, 1'b0, 8'd11},  // R11
      '{12'h300, 2'd1, 16'hFFFF, 1'b0, 16'hFFFF, 16'hFFFF, 1'b0, 1'b0, 8'd12},  // R12
      '{12'h104, 2'd1, 16'h0000, 1'b0, 16'hFFFF, 16'h0000, 1'b0, 1'b0, 8'd9 },  // R9
      '{12'h204, 2'd1, 16'h0000, 1'b0, 16'h0000, 16'h0040, 1'b0, 1'b0, 8'd4 }   // R4
   };

   logic            clk = 1'b0;
   logic            rst_n;
   logic            req_valid;
   logic [11:0]     req_addr;
   logic [1:0]      req_op;
   logic [XLEN-1:0] req_wdata, mideleg, hideleg;
   logic            virt_mode, vs_timer_irq, vs_ext_irq;
   logic [XLEN-1:0] rdata, mie_q, mip_q;
   logic            rvalid;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   hvirq_csr_alias u_hvirq_csr_alias (
      .clk, .rst_n, .req_valid, .req_addr, .req_op, .req_wdata, .virt_mode,
      .mideleg, .hideleg, .vs_timer_irq, .vs_ext_irq,
      .rdata, .rvalid, .mie_q, .mip_q
   );

   // reference state, built from the requirements
   logic [XLEN-1:0] m_mie, m_mip;

   function automatic logic [XLEN-1:0] model_step(vec_t v);
      logic [XLEN-1:0] mask, data, fmip, em, rd, mid, hid;
      logic [11:0] a;
      mid = XLEN'(v.mid);
      hid = XLEN'(v.hid);
      case (v.op)
         2'd1:    begin mask = '1;          data = XLEN'(v.wd); end
         2'd2:    begin mask = XLEN'(v.wd); data = '1;          end
         2'd3:    begin mask = XLEN'(v.wd); data = '0;          end
         default: begin mask = '0;          data = '0;          end
      endcase
      fmip = m_mip | (XLEN'(v.vt) << 6) | (XLEN'(v.ve) << 10);
      a = v.addr;
      if (v.virt && a == 12'h104) a = 12'h204;
      if (v.virt && a == 12'h144) a = 12'h244;
      rd = '0;
      case (a)
         12'h104: begin
            rd = m_mie & mid; em = mask & 64'h222;
            m_mie = (m_mie & ~em) | (data & em);
         end
         12'h144: begin
            rd = fmip & mid; em = mask & mid & 64'h2;
            m_mip = (m_mip & ~em) | (data & em);
         end
         12'h204: begin
            rd = (m_mie & hid & 64'h444) >> 1; em = (mask << 1) & hid & 64'h444;
            m_mie = (m_mie & ~em) | ((data << 1) & em);
         end
         12'h244: begin
            rd = (fmip & 64'h444) >> 1; em = (mask << 1) & hid & 64'h4;
            m_mip = (m_mip & ~em) | ((data << 1) & em);
         end
         default: rd = '0;
      endcase
      return rd;
   endfunction

   task automatic check(string tag, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   initial begin
      rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_op = '0; req_wdata = '0;
      virt_mode = 1'b0; mideleg = '0; hideleg = '0; vs_timer_irq = 1'b0; vs_ext_irq = 1'b0;
      m_mie = '0; m_mip = '0;
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 mie", mie_q, '0);
      check("R1 mip", mip_q, '0);
      check("R1 rvalid", XLEN'(rvalid), '0);
      check("R1 rdata", rdata, '0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 mie after release", mie_q, '0);

      for (int i = 0; i < NV; i++) begin
         vec_t v;
         logic [XLEN-1:0] exp_rd;
         string tag;
         v = VECS[i];
         req_valid = 1'b1; req_addr = v.addr; req_op = v.op; req_wdata = XLEN'(v.wd);
         virt_mode = v.virt; mideleg = XLEN'(v.mid); hideleg = XLEN'(v.hid);
         vs_timer_irq = v.vt; vs_ext_irq = v.ve;
         exp_rd = model_step(v);
         @(negedge clk);
         tag = $sformatf("R%0d vec%0d", v.req, i);
         check({tag, " R2 rvalid"}, XLEN'(rvalid), XLEN'(1));
         check({tag, " rdata"}, rdata, exp_rd);
         check({tag, " mie"}, mie_q, m_mie);
         check({tag, " mip"}, mip_q, m_mip | (XLEN'(v.vt) << 6) | (XLEN'(v.ve) << 10));
         req_valid = 1'b0;
      end

      // R2: no request, no valid
      vs_timer_irq = 1'b0; vs_ext_irq = 1'b0;
      @(negedge clk);
      check("R2 idle rvalid", XLEN'(rvalid), '0);
      // R6: pending pins appear without any access, and did not stick
      check("R6 pins low", mip_q, m_mip);
      vs_timer_irq = 1'b1;
      #1;
      check("R6 timer pin", mip_q, m_mip | 64'h40);
      vs_timer_irq = 1'b0;
      // R1: reset again clears stored state
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 second reset mie", mie_q, '0);
      check("R1 second reset mip", mip_q, '0);
      rst_n = 1'b1;
      @(negedge clk);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule